// File: doc/BRIEF.md
# BCD Real-Time Clock with Freeze Buffer

This block keeps calendar time in binary-coded decimal: hundredths, seconds, minutes, hours, day of week, date, month and two-digit year. A 100 Hz pulse advances it. It holds two copies of the time. The internal copy always counts. The visible copy is what a byte-wide register bus reads.

The visible hundredths follow the internal count on every tick. The upper fields (seconds through years) step inside the internal copy when hundredths enters 99, and become visible on the 99 to 00 rollover. Software clears a transfer-enable bit to freeze the visible copy, reads or writes it at leisure, and then sets the bit again. No time is lost while the copy is frozen.

A run bit stops or starts counting. A second bit gates a 1024 Hz square wave. The square wave is made by dividing a 32.768 kHz pulse by 32. Hours can be kept in 24-hour form or in 12-hour form with an AM/PM flag.

Top module: `rtc_freeze_core`

## Requirements
- R1: Register map: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month/control, 7 year, 8 command. After reset these read 00, 00, 00, 00, 01, 01, C1, 00, 80.
- R2: Month register bit 7 is a stop bit. When it is 1, 100 Hz ticks have no effect on any time register. When it is 0, each tick advances the count.
- R3: Hundredths counts 00..99 in BCD. While transfer enable is 1, its visible value changes on every tick, and 99 wraps to 00.
- R4: The tick that takes hundredths from 98 to 99 steps the internal upper fields. The visible upper fields show the new value only after the tick that takes hundredths from 99 to 00, so seconds still reads its old value while hundredths reads 99.
- R5: Command bit 7 is transfer enable. While it is 0, every visible register holds its value and the internal count keeps running. After it is set back to 1, the next tick shows the full elapsed time.
- R6: Seconds and minutes count 00..59 in BCD. Each carries into the next field on the wrap from 59 to 00.
- R7: Hours bit 6 = 0 selects 24-hour form, with bits 5:0 holding BCD 00..23. The wrap from 23 to 00 advances the day.
- R8: Hours bit 6 = 1 selects 12-hour form. Bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01..12. Going from 11 to 12 toggles PM, and 12 goes to 01. The day advances on PM 11 to AM 12.
- R9: Day of week counts 1..7 and wraps 7 to 1. Date wraps to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: Unused bits read 0. The readable bit masks are FF, 7F, 7F, 7F, 07, 3F, DF, FF and 80 for addresses 0..8. Month bits 7:6 hold exactly what was written. Addresses 9..15 read 00.
- R11: A bus write to a time register sets both copies at once. The written value reads back immediately, even while frozen, and counting continues from it.
- R12: sqw_o toggles after every 16 pulses of osc_tick while the clock runs, giving a period of 32 pulses. sqw_oe is the inverse of month bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| osc_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sqw_o | output | 1 | 1024 Hz square-wave level |
| sqw_oe | output | 1 | Pad drive enable; the pin floats when this is 0 |

## Verification
A wrong carry or a wrong month length in the internal copy does not show at once. It shows on the bus at the first rollover after the fault, which is two ticks after a write of hundredths 98. The sweeps therefore put the time just before every second, minute, hour, month-end and year-end value and check the visible fields on exactly that rollover tick. A copy rule that is wrong shows up instead at the moment hundredths reads 99, or on the first tick after a freeze ends. Both moments are checked.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// rtc_pkg: shared types, register addresses and BCD helpers for the clock.
// Assumes all time fields hold valid BCD unless software writes otherwise.
package rtc_pkg;

    localparam int AW = 4;
    typedef logic [AW-1:0] addr_t;

    localparam addr_t A_HS   = addr_t'(0);
    localparam addr_t A_SEC  = addr_t'(1);
    localparam addr_t A_MIN  = addr_t'(2);
    localparam addr_t A_HOUR = addr_t'(3);
    localparam addr_t A_DOW  = addr_t'(4);
    localparam addr_t A_DATE = addr_t'(5);
    localparam addr_t A_MON  = addr_t'(6);
    localparam addr_t A_YEAR = addr_t'(7);
    localparam addr_t A_CMD  = addr_t'(8);

    // Calendar above hundredths, stored without unused bits
    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 7'h00, min: 7'h00, hour: 7'h00,
                                   dow: 3'd1, date: 6'h01, month: 5'h01,
                                   year: 8'h00};

    // Add one to a two-digit BCD value (no wrap handling)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last date of a month in BCD, leap year when year mod 4 == 0
    function automatic logic [5:0] last_date(input logic [4:0] mon,
                                             input logic [7:0] yr);
        logic [1:0] m4;
        m4 = yr[1:0] + {yr[4], 1'b0};
        case (mon)
            5'h02:                      return (m4 == 2'd0) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // Readable bits for each register address
    function automatic logic [7:0] field_mask(input addr_t a);
        case (a)
            A_HS, A_YEAR:         return 8'hFF;
            A_SEC, A_MIN, A_HOUR: return 8'h7F;
            A_DOW:                return 8'h07;
            A_DATE:               return 8'h3F;
            A_MON:                return 8'hDF;
            A_CMD:                return 8'h80;
            default:              return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
// rtc_cal_step: combinational one-second advance of the calendar.
// Handles 12/24-hour forms, month lengths, leap years and year wrap.
// Assumes the current value is valid BCD; invalid input gives an unspecified result.
module rtc_cal_step
    import rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);

    logic       day_roll;
    logic [4:0] h12;
    logic       pm;
    logic [5:0] h24;

    assign h12 = cur.hour[4:0];
    assign pm  = cur.hour[5];
    assign h24 = cur.hour[5:0];

    // Ripple the one-second carry through every field
    always_comb begin
        nxt      = cur;
        day_roll = 1'b0;
        if (cur.sec != 7'h59) begin
            nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
        end else begin
            nxt.sec = 7'h00;
            if (cur.min != 7'h59) begin
                nxt.min = 7'(bcd_inc({1'b0, cur.min}));
            end else begin
                nxt.min = 7'h00;
                if (cur.hour[6]) begin
                    if (h12 == 5'h12) begin
                        nxt.hour = {1'b1, pm, 5'h01};
                    end else if (h12 == 5'h11) begin
                        nxt.hour = {1'b1, ~pm, 5'h12};
                        day_roll = pm;
                    end else begin
                        nxt.hour = {1'b1, pm, 5'(bcd_inc({3'b0, h12}))};
                    end
                end else begin
                    if (h24 == 6'h23) begin
                        nxt.hour = 7'h00;
                        day_roll = 1'b1;
                    end else begin
                        nxt.hour = {1'b0, 6'(bcd_inc({2'b0, h24}))};
                    end
                end
            end
        end
        if (day_roll) begin
            nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date == last_date(cur.month, cur.year)) begin
                nxt.date = 6'h01;
                if (cur.month == 5'h12) begin
                    nxt.month = 5'h01;
                    nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
                end else begin
                    nxt.month = 5'(bcd_inc({3'b0, cur.month}));
                end
            end else begin
                nxt.date = 6'(bcd_inc({2'b0, cur.date}));
            end
        end
    end

    // Range guards on the stepped value
    always_comb begin
        if (cur.sec[6:4] <= 3'd5 && cur.sec[3:0] <= 4'd9) begin
            p_sec_range_r6: assert (nxt.sec[6:4] <= 3'd5 && nxt.sec[3:0] <= 4'd9)
                else $error("seconds left 00..59");
        end
        if (cur.dow >= 3'd1) begin
            p_dow_range_r9: assert (nxt.dow >= 3'd1)
                else $error("day of week left 1..7");
        end
    end

endmodule

// File: rtl/rtc_sqw_div.sv
`timescale 1ns/1ps
// rtc_sqw_div: divides the oscillator pulse by 2*HALF into a square wave.
// Assumes osc_tick is a one-cycle pulse in the clk domain; holds while run is low.
module rtc_sqw_div #(
    parameter int HALF = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    output logic sq
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Count oscillator pulses and flip the output every HALF of them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (osc_tick && run) begin
            if (cnt == LAST) begin
                cnt <= '0;
                sq  <= ~sq;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_half_period_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && run && cnt == LAST) |=> (sq != $past(sq)));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_tick && run) |=> $stable(sq));

endmodule

// File: rtl/rtc_freeze_core.sv
`timescale 1ns/1ps
// rtc_freeze_core: BCD time of day with an internal count and a visible copy.
// The upper fields step when hundredths enters 99 and are copied out on the
// rollover to 00. The copy is held while transfer enable is 0.
// Assumes tick_100hz and osc_tick are one-cycle pulses synchronous to clk
// and that bus writes never coincide with a tick the caller cares about.
module rtc_freeze_core
    import rtc_pkg::*;
#(
    parameter int SQW_HALF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_100hz,
    input  logic          osc_tick,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          sqw_o,
    output logic          sqw_oe
);

    cal_t       int_cal, ext_cal, cal_step;
    logic [7:0] int_hs, ext_hs, hs_next, wd;
    logic       osc_off, sqw_off, xfer_en;
    logic       tick_ok, upper_step, copy_hs, copy_upper;

    assign wd         = bus_wdata & field_mask(bus_addr);
    assign tick_ok    = tick_100hz & ~osc_off;
    assign upper_step = tick_ok & (int_hs == 8'h98);
    assign hs_next    = (int_hs == 8'h99) ? 8'h00 : bcd_inc(int_hs);
    assign copy_hs    = tick_ok & xfer_en;
    assign copy_upper = tick_ok & xfer_en & (int_hs != 8'h98);

    rtc_cal_step step_i (
        .cur (int_cal),
        .nxt (cal_step)
    );

    // Hundredths: both copies; a write beats a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_hs <= 8'h00;
            ext_hs <= 8'h00;
        end else if (bus_we && bus_addr == A_HS) begin
            int_hs <= wd;
            ext_hs <= wd;
        end else begin
            if (tick_ok) int_hs <= hs_next;
            if (copy_hs) ext_hs <= hs_next;
        end
    end

    // Internal calendar: step on entry to 99, bus writes override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_cal <= CAL_RESET;
        end else begin
            if (upper_step) int_cal <= cal_step;
            if (bus_we) begin
                case (bus_addr)
                    A_SEC:   int_cal.sec   <= wd[6:0];
                    A_MIN:   int_cal.min   <= wd[6:0];
                    A_HOUR:  int_cal.hour  <= wd[6:0];
                    A_DOW:   int_cal.dow   <= wd[2:0];
                    A_DATE:  int_cal.date  <= wd[5:0];
                    A_MON:   int_cal.month <= wd[4:0];
                    A_YEAR:  int_cal.year  <= wd;
                    default: ;
                endcase
            end
        end
    end

    // Visible calendar: copy outside the 99 window, bus writes override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_cal <= CAL_RESET;
        end else begin
            if (copy_upper) ext_cal <= int_cal;
            if (bus_we) begin
                case (bus_addr)
                    A_SEC:   ext_cal.sec   <= wd[6:0];
                    A_MIN:   ext_cal.min   <= wd[6:0];
                    A_HOUR:  ext_cal.hour  <= wd[6:0];
                    A_DOW:   ext_cal.dow   <= wd[2:0];
                    A_DATE:  ext_cal.date  <= wd[5:0];
                    A_MON:   ext_cal.month <= wd[4:0];
                    A_YEAR:  ext_cal.year  <= wd;
                    default: ;
                endcase
            end
        end
    end

    // Control bits: stop, square-wave off, transfer enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_off <= 1'b1;
            sqw_off <= 1'b1;
            xfer_en <= 1'b1;
        end else if (bus_we) begin
            if (bus_addr == A_MON) begin
                osc_off <= wd[7];
                sqw_off <= wd[6];
            end
            if (bus_addr == A_CMD) xfer_en <= wd[7];
        end
    end

    // Read multiplexer over the visible copy
    always_comb begin
        case (bus_addr)
            A_HS:    bus_rdata = ext_hs;
            A_SEC:   bus_rdata = {1'b0, ext_cal.sec};
            A_MIN:   bus_rdata = {1'b0, ext_cal.min};
            A_HOUR:  bus_rdata = {1'b0, ext_cal.hour};
            A_DOW:   bus_rdata = {5'b0, ext_cal.dow};
            A_DATE:  bus_rdata = {2'b0, ext_cal.date};
            A_MON:   bus_rdata = {osc_off, sqw_off, 1'b0, ext_cal.month};
            A_YEAR:  bus_rdata = ext_cal.year;
            A_CMD:   bus_rdata = {xfer_en, 7'b0};
            default: bus_rdata = 8'h00;
        endcase
    end

    rtc_sqw_div #(.HALF(SQW_HALF)) sqw_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run      (~osc_off),
        .sq       (sqw_o)
    );

    assign sqw_oe = ~sqw_off;

    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz && osc_off && !bus_we) |=> ($stable(int_hs) && $stable(int_cal)));
    p_hs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && int_hs == 8'h99 && !bus_we) |=> (int_hs == 8'h00));
    p_rollover_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && xfer_en && int_hs == 8'h99 && !bus_we) |=> (ext_cal == $past(int_cal)));
    p_hidden_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && int_hs == 8'h98 && !bus_we) |=> $stable(ext_cal));
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && !bus_we) |=> ($stable(ext_hs) && $stable(ext_cal)));
    p_write_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MIN) |=> (int_cal.min == ext_cal.min));

endmodule

// File: tb/rtc_freeze_core_tb.sv
`timescale 1ns/1ps
// rtc_freeze_core_tb_top: sweeps rollovers of every field and checks the copy rules.
module rtc_freeze_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       osc_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sqw_o, sqw_oe;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    rtc_freeze_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .osc_tick(osc_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sqw_o(sqw_o), .sqw_oe(sqw_oe)
    );

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] enc12(input int h);
        int t = h % 12;
        if (t == 0) t = 12;
        return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(t);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input int a, input logic [7:0] exp);
        bus_addr = 4'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk); tick_100hz = 1'b1;
        @(negedge clk); tick_100hz = 1'b0;
    endtask

    task automatic osc();
        @(negedge clk); osc_tick = 1'b1;
        @(negedge clk); osc_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] hs, s, m, h, dw, dt, mo, y);
        wr(1, s); wr(2, m); wr(3, h); wr(4, dw); wr(5, dt); wr(6, mo); wr(7, y);
        wr(0, hs);
    endtask

    initial begin
        logic [7:0] mask [0:8] = '{8'hFF, 8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'hDF, 8'hFF, 8'h80};
        logic [7:0] rst_v [0:8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'hC1, 8'h00, 8'h80};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 9; a++) chk_rd("R1 reset value", a, rst_v[a]);
        chk("R1 reset sqw_oe", {7'b0, sqw_oe}, 8'h00);

        // R2 stopped after reset: ticks ignored
        repeat (5) tick();
        chk_rd("R2 stopped hundredths", 0, 8'h00);
        wr(6, 8'h01);
        tick();
        chk_rd("R2 running hundredths", 0, 8'h01);
        wr(6, 8'h81);
        repeat (3) tick();
        chk_rd("R2 stopped again", 0, 8'h01);
        chk_rd("R2 month reads stop bit", 6, 8'h81);

        // R3 full hundredths sweep and wrap with seconds carry
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        for (int i = 1; i <= 100; i++) begin
            tick();
            chk_rd("R3 hundredths", 0, bcd(i % 100));
        end
        chk_rd("R3 seconds after wrap", 1, 8'h01);

        // R4 upper fields hidden while hundredths is 99
        set_time(8'h98, 8'h07, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick();
        chk_rd("R4 hundredths at 99", 0, 8'h99);
        chk_rd("R4 seconds still old", 1, 8'h07);
        tick();
        chk_rd("R4 seconds after rollover", 1, 8'h08);

        // R6 seconds and minutes sweeps
        for (int s = 0; s < 60; s++) begin
            set_time(8'h98, bcd(s), 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
            tick(); tick();
            chk_rd("R6 seconds step", 1, bcd((s + 1) % 60));
            chk_rd("R6 minute carry", 2, (s == 59) ? 8'h11 : 8'h10);
        end
        for (int m = 0; m < 60; m++) begin
            set_time(8'h98, 8'h59, bcd(m), 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
            tick(); tick();
            chk_rd("R6 minutes step", 2, bcd((m + 1) % 60));
            chk_rd("R6 hour carry", 3, (m == 59) ? 8'h06 : 8'h05);
        end

        // R7 24-hour sweep; R8 12-hour sweep
        for (int h = 0; h < 24; h++) begin
            set_time(8'h98, 8'h59, 8'h59, bcd(h), 8'h03, 8'h15, 8'h05, 8'h21);
            tick(); tick();
            chk_rd("R7 hour 24h", 3, bcd((h + 1) % 24));
            chk_rd("R7 date roll", 5, (h == 23) ? 8'h16 : 8'h15);
            set_time(8'h98, 8'h59, 8'h59, enc12(h), 8'h03, 8'h15, 8'h05, 8'h21);
            tick(); tick();
            chk_rd("R8 hour 12h", 3, enc12((h + 1) % 24));
            chk_rd("R8 date roll", 5, (h == 23) ? 8'h16 : 8'h15);
            chk_rd("R8 dow roll", 4, (h == 23) ? 8'h04 : 8'h03);
        end

        // R9 month ends across leap and non-leap years, year wrap
        for (int y = 96; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h07, bcd(mdays(m, y)), bcd(m), bcd(y));
                tick(); tick();
                chk_rd("R9 date wrap", 5, 8'h01);
                chk_rd("R9 month step", 6, bcd((m % 12) + 1));
                chk_rd("R9 year", 7, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
                chk_rd("R9 dow wrap", 4, 8'h01);
            end
            set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, bcd(y));
            tick(); tick();
            chk_rd("R9 february 28", 5, (y % 4 == 0) ? 8'h29 : 8'h01);
        end

        // R5 freeze and R11 writes while frozen
        wr(8, 8'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        repeat (150) tick();
        chk_rd("R5 frozen hundredths", 0, 8'h00);
        chk_rd("R5 frozen seconds", 1, 8'h00);
        chk_rd("R5 command reads 0", 8, 8'h00);
        wr(2, 8'h33);
        chk_rd("R11 write while frozen", 2, 8'h33);
        wr(8, 8'h80);
        tick();
        chk_rd("R5 elapsed hundredths", 0, 8'h51);
        chk_rd("R5 elapsed seconds", 1, 8'h01);
        chk_rd("R11 written minutes kept", 2, 8'h33);

        // R10 unused bits and unmapped addresses
        for (int a = 0; a < 16; a++) begin
            wr(a, 8'hFF);
            chk_rd("R10 readable bits", a, (a < 9) ? mask[a] : 8'h00);
        end
        wr(6, 8'h41);
        chk_rd("R10 month control bits", 6, 8'h41);

        // R12 square wave
        wr(6, 8'h01);
        chk("R12 sqw_oe on", {7'b0, sqw_oe}, 8'h01);
        repeat (15) osc();
        chk("R12 sqw before half", {7'b0, sqw_o}, 8'h00);
        osc();
        chk("R12 sqw after 16", {7'b0, sqw_o}, 8'h01);
        repeat (16) osc();
        chk("R12 sqw after 32", {7'b0, sqw_o}, 8'h00);
        wr(6, 8'h41);
        chk("R12 sqw_oe off", {7'b0, sqw_oe}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule